// File: doc/BRIEF.md
# Re-reading ring buffer between two clock domains

This block carries a stream of data items from a writer clocked by one clock to a reader clocked by another, unrelated clock. The items are kept in a ring of cells. The writer side uses a valid/ready handshake. It is held up only when its next cell is the one the reader currently sits on. The reader side is a plain read strobe that always returns an item in the cycle after the strobe. When a newer item has arrived, the reader moves one cell forward and returns it. Otherwise it returns the cell it already holds again and raises a re-read flag.

Each side owns one ring pointer. Only that pointer's code crosses to the other domain, through a two-stage synchronizer. The code is a cyclic Gray sequence, so a sample taken during a change is either the old position or the new one. A late view of the other side's pointer therefore costs the writer a few extra wait cycles, or gives the reader one more re-read. It never lets the two sides meet on one cell. Items are never lost or reordered, and the only repeats are those flagged as re-reads.

The cell count `CELLS` must be even and at least 4. Every cell, and the read output register, starts from the parameter `INIT_DATA`.

Top module: `rr_ring_link`

## Requirements
- R1: After both resets, wrReady is 1, rdData equals INIT_DATA and rdReread is 0. Every cell holds INIT_DATA, the writer pointer is 1 and the reader pointer is 0.
- R2: On a wrClk edge where wrValid and wrReady are both 1, wrData is stored in the writer's current cell and the writer pointer advances by one, modulo CELLS.
- R3: With the reader idle, the writer accepts exactly CELLS-2 items beyond the reader's current cell. wrReady then stays 0.
- R4: On a rdClk edge with rdStrobe at 1, one of two things happens. If the cell after the reader's cell is not the writer's cell as seen through the synchronizer, the reader advances, rdData takes that next cell and rdReread becomes 0. Otherwise rdData takes the reader's own cell again and rdReread becomes 1. Both outputs hold between strobes.
- R5: wrValid held at 1 while wrReady is 0 stores nothing and does not move the writer pointer.
- R6: Successive reads return the items in write order. Each read returns either the previous item again, with rdReread at 1, or the next item written, with rdReread at 0. No item is skipped.
- R7: Once the reader has advanced away from the cell after the writer's cell, wrReady returns to 1 within a few wrClk cycles.
- R8: Asserting both resets in the middle of operation restores the R1 state and discards the stored items.
- R9: The writer never writes the cell the reader is on, and the reader pointer never equals the writer pointer as seen by the reader.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Writer clock |
| wrRstN | input | 1 | Writer-domain reset, active low |
| wrValid | input | 1 | Writer offers an item |
| wrReady | output | 1 | Writer's next cell is free of the reader |
| wrData | input | DW | Item to store |
| rdClk | input | 1 | Reader clock |
| rdRstN | input | 1 | Reader-domain reset, active low |
| rdStrobe | input | 1 | Reader takes one item |
| rdData | output | DW | Item returned by the last strobe |
| rdReread | output | 1 | Last strobe returned the same cell again |

## Verification
The reader is exercised in four situations, and each one separates a different outcome:
- a strobe straight after reset, which shows that an empty ring re-reads the initial cell;
- a single written item, which shows one advance followed by a flagged repeat;
- a ring filled while the reader is idle, which shows the CELLS-2 blocking point and that a held offer is ignored while blocked;
- two concurrent streams on unrelated clocks.

In the streams, a writer with no gaps keeps the writer blocked behind the reader. A writer with long gaps forces frequent re-reads. Both streams must still deliver the full sequence in order across many ring wraps. A reset in the middle of operation, with unread items in the ring, shows that those items are discarded.

// File: rtl/rr_ring_pkg.sv
package rr_ring_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic cellWrite;    // store wrData in the writer's cell (wrClk)
    logic readTake;     // load the read register (rdClk)
    logic readAdvance;  // this take moved the reader forward (rdClk)
  } ringStrobes_t;
endpackage

// File: rtl/rr_ring_sync.sv
module rr_ring_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/rr_ring_ctrl.sv
module rr_ring_ctrl
  import rr_ring_pkg::*;
#(
  parameter int CELLS = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IW = $clog2(CELLS)
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrValid,
  output logic          wrReady,
  output logic [IW-1:0] wrIdx,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdStrobe,
  output logic [IW-1:0] rdIdx,
  output ringStrobes_t  strobes
);
  localparam int SPAN = 2 ** IW;
  localparam logic [IW-1:0] HALF_P = IW'(CELLS / 2);
  localparam logic [IW-1:0] OFFS   = IW'(SPAN - CELLS);
  localparam logic [IW-1:0] LAST   = IW'(CELLS - 1);
  localparam logic [IW-1:0] ONE    = IW'(1);
  localparam logic [IW-1:0] ZERO   = '0;

  // Cyclic Gray code for an even ring: use the low half and the mirrored
  // high half of the full Gray sequence, so every step, including the wrap,
  // changes exactly one bit.
  function automatic logic [IW-1:0] toCode(input logic [IW-1:0] idx);
    logic [IW-1:0] b;
    b = (idx < HALF_P) ? idx : idx + OFFS;
    return b ^ (b >> 1);
  endfunction

  function automatic logic [IW-1:0] fromCode(input logic [IW-1:0] g);
    logic [IW-1:0] b;
    b[IW-1] = g[IW-1];
    for (int i = IW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return (b < HALF_P) ? b : b - OFFS;
  endfunction

  localparam logic [IW-1:0] W_INIT_CODE = toCode(ONE);
  localparam logic [IW-1:0] R_INIT_CODE = toCode(ZERO);

  // ---------------- writer domain ----------------
  logic [IW-1:0] wPtr, wNext, wCode, rSeenCode, rSeen;
  logic          wAccept;

  // reader's pointer code, defined after the reader section below
  logic [IW-1:0] rCode;

  rr_ring_sync #(.W(IW), .STAGES(SYNC_STAGES), .RST(R_INIT_CODE)) uRdToWr (
    .clk(wrClk), .rstN(wrRstN), .din(rCode), .dout(rSeenCode)
  );

  assign rSeen   = fromCode(rSeenCode);
  assign wNext   = (wPtr == LAST) ? ZERO : wPtr + ONE;
  assign wrReady = (wNext != rSeen);
  assign wAccept = wrValid && wrReady;
  assign wrIdx   = wPtr;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wPtr  <= ONE;
      wCode <= W_INIT_CODE;
    end else if (wAccept) begin
      wPtr  <= wNext;
      wCode <= toCode(wNext);
    end
  end

  // R9
  wr_no_clash_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wAccept |-> (wPtr != rSeen));

  // R5
  wr_hold_blocked_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrValid && !wrReady) |=> $stable(wPtr));

  // ---------------- reader domain ----------------
  logic [IW-1:0] rPtr, rNext, wSeenCode, wSeen;
  logic          canAdvance, rAdvance;

  rr_ring_sync #(.W(IW), .STAGES(SYNC_STAGES), .RST(W_INIT_CODE)) uWrToRd (
    .clk(rdClk), .rstN(rdRstN), .din(wCode), .dout(wSeenCode)
  );

  assign wSeen      = fromCode(wSeenCode);
  assign rNext      = (rPtr == LAST) ? ZERO : rPtr + ONE;
  assign canAdvance = (rNext != wSeen);
  assign rAdvance   = rdStrobe && canAdvance;
  assign rdIdx      = canAdvance ? rNext : rPtr;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rPtr  <= ZERO;
      rCode <= R_INIT_CODE;
    end else if (rAdvance) begin
      rPtr  <= rNext;
      rCode <= toCode(rNext);
    end
  end

  // R9
  rd_no_clash_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rPtr != wSeen);

  // R4
  rd_idle_hold_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rdStrobe |=> $stable(rPtr));

  assign strobes.cellWrite   = wAccept;
  assign strobes.readTake    = rdStrobe;
  assign strobes.readAdvance = rAdvance;
endmodule

// File: rtl/rr_ring_data.sv
module rr_ring_data
  import rr_ring_pkg::*;
#(
  parameter int CELLS = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] INIT_DATA = '0,
  localparam int IW = $clog2(CELLS)
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic [DW-1:0] wrData,
  input  logic [IW-1:0] wrIdx,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic [IW-1:0] rdIdx,
  input  ringStrobes_t  strobes,
  output logic [DW-1:0] rdData,
  output logic          rdReread
);
  logic [DW-1:0] cells [CELLS];

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      for (int i = 0; i < CELLS; i++) cells[i] <= INIT_DATA;
    end else if (strobes.cellWrite) begin
      cells[wrIdx] <= wrData;
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdData   <= INIT_DATA;
      rdReread <= 1'b0;
    end else if (strobes.readTake) begin
      rdData   <= cells[rdIdx];
      rdReread <= !strobes.readAdvance;
    end
  end

  // R4
  reread_same_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (strobes.readTake && !strobes.readAdvance) |=> $stable(rdData));

  // R4
  reread_flag_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    strobes.readTake |=> (rdReread == !$past(strobes.readAdvance)));
endmodule

// File: rtl/rr_ring_link.sv
module rr_ring_link
  import rr_ring_pkg::*;
#(
  parameter int CELLS = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] INIT_DATA = '0,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          wrValid,
  output logic          wrReady,
  input  logic [DW-1:0] wrData,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdStrobe,
  output logic [DW-1:0] rdData,
  output logic          rdReread
);
  localparam int IW = $clog2(CELLS);

  logic [IW-1:0] wrIdx, rdIdx;
  ringStrobes_t  strobes;

  rr_ring_ctrl #(.CELLS(CELLS), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrReady(wrReady),
    .wrIdx(wrIdx), .rdClk(rdClk), .rdRstN(rdRstN), .rdStrobe(rdStrobe),
    .rdIdx(rdIdx), .strobes(strobes)
  );

  rr_ring_data #(.CELLS(CELLS), .DW(DW), .INIT_DATA(INIT_DATA)) uData (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrData(wrData), .wrIdx(wrIdx),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdIdx(rdIdx), .strobes(strobes),
    .rdData(rdData), .rdReread(rdReread)
  );
endmodule

// File: tb/test_rr_ring_link.sv
module test_rr_ring_link;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD * 7 / 5;
  localparam int CELLS = 4;
  localparam int DW = 8;
  localparam logic [DW-1:0] INIT = 8'h5A;

  logic wrClk = 0, rdClk = 0;
  logic wrRstN = 0, rdRstN = 0;
  logic wrValid = 0, rdStrobe = 0;
  logic [DW-1:0] wrData = '0;
  logic wrReady, rdReread;
  logic [DW-1:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2)  rdClk = ~rdClk;

  rr_ring_link #(.CELLS(CELLS), .DW(DW), .INIT_DATA(INIT)) i_rr_ring_link (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrReady(wrReady),
    .wrData(wrData), .rdClk(rdClk), .rdRstN(rdRstN), .rdStrobe(rdStrobe),
    .rdData(rdData), .rdReread(rdReread)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    wrRstN = 0; rdRstN = 0; wrValid = 0; rdStrobe = 0;
    repeat (3) @(negedge rdClk);
    @(negedge wrClk); wrRstN = 1;
    @(negedge rdClk); rdRstN = 1;
    repeat (2) @(negedge wrClk);
  endtask

  task automatic settle();
    repeat (5) @(negedge rdClk);
    repeat (5) @(negedge wrClk);
  endtask

  task automatic pushOne(input logic [DW-1:0] d, output bit took);
    @(negedge wrClk);
    wrValid = 1; wrData = d;
    took = wrReady;
    @(negedge wrClk);
    wrValid = 0;
  endtask

  task automatic readOne(output logic [DW-1:0] d, output bit rr);
    @(negedge rdClk);
    rdStrobe = 1;
    @(negedge rdClk);
    rdStrobe = 0;
    d = rdData; rr = rdReread;
  endtask

  task automatic testReset();
    check(wrReady == 1, "R1", "wrReady after reset", int'(wrReady), 1);
    check(rdData == INIT, "R1", "rdData after reset", int'(rdData), int'(INIT));
    check(rdReread == 0, "R1", "rdReread after reset", int'(rdReread), 0);
  endtask

  task automatic testEmptyRead();
    logic [DW-1:0] d; bit rr;
    readOne(d, rr);
    check(d == INIT, "R4", "empty read data", int'(d), int'(INIT));
    check(rr == 1, "R4", "empty read flag", int'(rr), 1);
  endtask

  task automatic testSingle();
    logic [DW-1:0] d; bit rr; bit took;
    pushOne(8'h11, took);
    check(took == 1, "R2", "single accept", int'(took), 1);
    settle();
    readOne(d, rr);
    check(d == 8'h11, "R2", "single read data", int'(d), 'h11);
    check(rr == 0, "R4", "single read flag", int'(rr), 0);
    readOne(d, rr);
    check(d == 8'h11, "R4", "repeat read data", int'(d), 'h11);
    check(rr == 1, "R4", "repeat read flag", int'(rr), 1);
  endtask

  task automatic testFill();
    logic [DW-1:0] d; bit rr; bit took;
    int accepted = 0;
    for (int k = 0; k < CELLS + 2; k++) begin
      pushOne(8'h21 + DW'(accepted), took);
      if (took) accepted++;
    end
    check(accepted == CELLS - 2, "R3", "items accepted idle reader", accepted, CELLS - 2);
    settle();
    check(wrReady == 0, "R3", "wrReady when full", int'(wrReady), 0);
    // R5: hold an offer while blocked
    @(negedge wrClk);
    wrValid = 1; wrData = 8'hEE;
    for (int k = 0; k < 3; k++) begin
      @(negedge wrClk);
      check(wrReady == 0, "R5", "ready low while offer held", int'(wrReady), 0);
    end
    wrValid = 0;
    for (int k = 0; k < CELLS - 2; k++) begin
      readOne(d, rr);
      check(d == 8'h21 + DW'(k), "R6", "fill read data", int'(d), 'h21 + k);
      check(rr == 0, "R6", "fill read flag", int'(rr), 0);
      if (k == 0) begin
        settle();
        check(wrReady == 1, "R7", "ready after reader moved", int'(wrReady), 1);
      end
    end
    readOne(d, rr);
    check(d == 8'h21 + DW'(CELLS - 3), "R5", "blocked offer not stored", int'(d), 'h21 + CELLS - 3);
    check(rr == 1, "R5", "reread after drain", int'(rr), 1);
  endtask

  task automatic testStream(input int gap, input int count, input bit wantRereads);
    int rereads = 0;
    int reads = 0;
    logic [DW-1:0] last;
    logic [DW-1:0] seen;
    last = INIT + DW'(count);
    seen = INIT;
    fork
      begin
        for (int k = 1; k <= count; k++) begin
          bit took;
          took = 0;
          while (!took) pushOne(INIT + DW'(k), took);
          repeat (gap) @(negedge wrClk);
        end
      end
      begin
        while (seen != last && reads < 2000) begin
          logic [DW-1:0] d; bit rr;
          readOne(d, rr);
          reads++;
          if (rr) begin
            rereads++;
            check(d == seen, "R6", "stream repeat value", int'(d), int'(seen));
          end else begin
            check(d == seen + 1'b1, "R6", "stream next value", int'(d), int'(seen + 1'b1));
          end
          seen = d;
        end
      end
    join
    check(seen == last, "R6", "stream final item", int'(seen), int'(last));
    if (wantRereads)
      check(rereads > 0, "R4", "slow writer gives rereads", rereads, 1);
  endtask

  task automatic testMidReset();
    logic [DW-1:0] d; bit rr; bit took;
    pushOne(8'h77, took);
    pushOne(8'h78, took);
    settle();
    doReset();
    check(wrReady == 1, "R8", "wrReady after mid reset", int'(wrReady), 1);
    check(rdData == INIT, "R8", "rdData after mid reset", int'(rdData), int'(INIT));
    check(rdReread == 0, "R8", "rdReread after mid reset", int'(rdReread), 0);
    settle();
    readOne(d, rr);
    check(d == INIT, "R8", "read after mid reset data", int'(d), int'(INIT));
    check(rr == 1, "R8", "read after mid reset flag", int'(rr), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    testReset();
    testEmptyRead();
    testSingle();
    testFill();
    doReset();
    testStream(0, 40, 0);
    doReset();
    testStream(6, 24, 1);
    testMidReset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule